// File: doc/BRIEF.md
# Text-Mode Cursor Overlay

This block decides, for every pixel of a character-cell text display, whether the cursor is drawn over it. The pixel pipeline supplies the cell now being painted (row and column on the character grid) and the scan line inside that cell. The block compares these with the cursor position it is given. It then applies the current shape, visibility and blink state and raises a single cursor bit. The pixel path XORs that bit with the glyph pixel, so the cursor shows as inverse video.

Five one-cycle command strobes set the cursor's look. One hides it. Two pick a shape, either the full cell or the bottom scan line, and also turn the cursor back on. Two choose between blinking and steady display. Shape and blink are held in separate registers. A frame tick, pulsed once per video frame, advances a blink timer. The phase flips every `TICKS_HALF` frames: 30 gives about half a second at 60 Hz, and 25 does the same at 50 Hz.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor is visible, block-shaped and blinking, and the blink phase is the shown half. The cursor cell is lit on every scan line.
- R2: A hide strobe makes `cursor_px` 0 for every pixel from the next cycle on, until a shape strobe arrives.
- R3: In block shape the cursor lights scan lines 0 to CELL_H-1 of the cell whose row and column both equal the cursor position. Every other cell stays dark.
- R4: In underscore shape only scan line CELL_H-1 (line 7 by default) of the cursor cell is lit.
- R5: A block or underscore strobe makes the cursor visible and sets its shape. It leaves the blink setting unchanged.
- R6: While blinking, the phase flips on the TICKS_HALF-th frame tick counted from the last flip or restart. The cursor is dark for the next TICKS_HALF ticks, then shown again.
- R7: In steady mode a visible cursor is shown whatever the blink phase, and frame ticks have no visible effect.
- R8: A blink strobe restarts the timer. The phase becomes the shown half, and the tick count starts again from zero.
- R9: When strobes arrive together, hide wins over both shape strobes, block wins over underscore, and steady wins over blink.
- R10: `cursor_px` follows the pixel inputs in the same cycle, with no register in between. A strobe takes effect on the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per video frame |
| cmd_hide | input | 1 | Strobe: hide the cursor |
| cmd_block | input | 1 | Strobe: show, full-cell shape |
| cmd_under | input | 1 | Strobe: show, bottom-line shape |
| cmd_blink | input | 1 | Strobe: blinking display, restart timer |
| cmd_steady | input | 1 | Strobe: non-blinking display |
| pix_line | input | LINE_W (3) | Scan line inside the current cell |
| cell_row | input | ROW_W (5) | Character row being painted |
| cell_col | input | COL_W (6) | Character column being painted |
| cur_row | input | ROW_W (5) | Cursor row |
| cur_col | input | COL_W (6) | Cursor column |
| cursor_px | output | 1 | Cursor covers this pixel |

## Verification
The hardest state to reach is a blink phase that sits in its dark half while the cursor still shows. That happens when steady mode is selected, and it is exactly the state a blink strobe must clear. The stimulus runs a full half-period of frame ticks in steady mode, where the output must stay lit, and then sends a blink strobe. It then counts TICKS_HALF-1 more ticks with the cursor lit and checks that the next tick darkens it. The edges of the blink window are also probed tick by tick, and simultaneous strobes are driven to check each priority.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    typedef enum logic {
        SHAPE_BLOCK = 1'b0,
        SHAPE_UNDER = 1'b1
    } shape_e;

    typedef struct packed {
        logic   visible;
        shape_e shape;
        logic   blink_en;
    } cur_mode_t;

    typedef struct packed {
        logic hide;
        logic block;
        logic under;
        logic blink;
        logic steady;
    } cur_cmd_t;

    localparam cur_mode_t MODE_RESET = '{visible: 1'b1, shape: SHAPE_BLOCK, blink_en: 1'b1};

    // Shape coverage of one scan line within a cell
    function automatic logic shape_covers(input shape_e shape, input logic is_last_line);
        return (shape == SHAPE_BLOCK) || is_last_line;
    endfunction

endpackage

// File: rtl/cursor_mode_reg.sv
module cursor_mode_reg
    import cursor_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cur_cmd_t  cmd,
    output cur_mode_t mode,
    output logic      blink_restart
);

    cur_mode_t mode_q;
    cur_mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (cmd.hide) begin
            mode_d.visible = 1'b0;
        end else if (cmd.block) begin
            mode_d.visible = 1'b1;
            mode_d.shape   = SHAPE_BLOCK;
        end else if (cmd.under) begin
            mode_d.visible = 1'b1;
            mode_d.shape   = SHAPE_UNDER;
        end
        if (cmd.steady) begin
            mode_d.blink_en = 1'b0;
        end else if (cmd.blink) begin
            mode_d.blink_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode          = mode_q;
    assign blink_restart = cmd.blink && !cmd.steady;

endmodule

// File: rtl/cursor_blink_timer.sv
module cursor_blink_timer #(
    parameter  int TICKS_HALF = 30,
    localparam int CNT_W      = (TICKS_HALF > 1) ? $clog2(TICKS_HALF) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    input  logic restart,
    output logic phase_on
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (frame_tick) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q   <= '0;
                phase_q <= !phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_on = phase_q;

endmodule

// File: rtl/cursor_cell_match.sv
module cursor_cell_match
    import cursor_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 6,
    parameter int LINE_W = 3,
    parameter int CELL_H = 8
) (
    input  cur_mode_t         mode,
    input  logic              phase_on,
    input  logic [LINE_W-1:0] pix_line,
    input  logic [ROW_W-1:0]  cell_row,
    input  logic [COL_W-1:0]  cell_col,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic [COL_W-1:0]  cur_col,
    output logic              hit
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(CELL_H - 1);

    logic at_cell;
    logic on_shape;
    logic lit_phase;

    always_comb begin
        at_cell   = (cell_row == cur_row) && (cell_col == cur_col);
        on_shape  = shape_covers(mode.shape, pix_line == LAST_LINE);
        lit_phase = !mode.blink_en || phase_on;
        hit       = mode.visible && at_cell && on_shape && lit_phase;
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter  int ROWS       = 25,
    parameter  int COLS       = 40,
    parameter  int CELL_H     = 8,
    parameter  int TICKS_HALF = 30,
    localparam int ROW_W      = $clog2(ROWS),
    localparam int COL_W      = $clog2(COLS),
    localparam int LINE_W     = $clog2(CELL_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic              cmd_hide,
    input  logic              cmd_block,
    input  logic              cmd_under,
    input  logic              cmd_blink,
    input  logic              cmd_steady,
    input  logic [LINE_W-1:0] pix_line,
    input  logic [ROW_W-1:0]  cell_row,
    input  logic [COL_W-1:0]  cell_col,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic [COL_W-1:0]  cur_col,
    output logic              cursor_px
);

    cur_cmd_t  cmd;
    cur_mode_t mode;
    logic      blink_restart;
    logic      phase_on;

    assign cmd = '{hide: cmd_hide, block: cmd_block, under: cmd_under,
                   blink: cmd_blink, steady: cmd_steady};

    cursor_mode_reg u_mode (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .mode          (mode),
        .blink_restart (blink_restart)
    );

    cursor_blink_timer #(.TICKS_HALF(TICKS_HALF)) u_blink (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .restart    (blink_restart),
        .phase_on   (phase_on)
    );

    cursor_cell_match #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .LINE_W (LINE_W),
        .CELL_H (CELL_H)
    ) u_match (
        .mode     (mode),
        .phase_on (phase_on),
        .pix_line (pix_line),
        .cell_row (cell_row),
        .cell_col (cell_col),
        .cur_row  (cur_row),
        .cur_col  (cur_col),
        .hit      (cursor_px)
    );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
    import cursor_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 6,
    parameter int LINE_W = 3,
    parameter int CELL_H = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_tick,
    input logic              cmd_hide,
    input logic              cmd_block,
    input logic              cmd_under,
    input logic              cmd_blink,
    input logic              cmd_steady,
    input logic [LINE_W-1:0] pix_line,
    input logic [ROW_W-1:0]  cell_row,
    input logic [COL_W-1:0]  cell_col,
    input logic [ROW_W-1:0]  cur_row,
    input logic [COL_W-1:0]  cur_col,
    input logic              cursor_px,
    input logic              visible,
    input logic              shape_under,
    input logic              blink_en,
    input logic              phase_on
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(CELL_H - 1);

    AST_HIDE_DARK: assert property (@(posedge clk) disable iff (rst)
        cmd_hide |=> !cursor_px);                                                       // R2
    AST_OFF_CELL_DARK: assert property (@(posedge clk) disable iff (rst)
        (cell_row != cur_row || cell_col != cur_col) |-> !cursor_px);                   // R3
    AST_UNDER_LAST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (shape_under && pix_line != LAST_LINE) |-> !cursor_px);                         // R4
    AST_SHAPE_KEEPS_BLINK: assert property (@(posedge clk) disable iff (rst)
        ((cmd_block || cmd_under) && !cmd_blink && !cmd_steady) |=> $stable(blink_en)); // R5
    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (phase_on != $past(phase_on)) |-> ($past(frame_tick) || $past(cmd_blink)));     // R6
    AST_STEADY_LIT: assert property (@(posedge clk) disable iff (rst)
        (visible && !blink_en && !shape_under && cell_row == cur_row && cell_col == cur_col)
        |-> cursor_px);                                                                 // R7
    AST_STEADY_WINS: assert property (@(posedge clk) disable iff (rst)
        cmd_steady |=> !blink_en);                                                      // R9

endmodule

bind cursor_overlay cursor_overlay_chk #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .LINE_W (LINE_W),
    .CELL_H (CELL_H)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_tick  (frame_tick),
    .cmd_hide    (cmd_hide),
    .cmd_block   (cmd_block),
    .cmd_under   (cmd_under),
    .cmd_blink   (cmd_blink),
    .cmd_steady  (cmd_steady),
    .pix_line    (pix_line),
    .cell_row    (cell_row),
    .cell_col    (cell_col),
    .cur_row     (cur_row),
    .cur_col     (cur_col),
    .cursor_px   (cursor_px),
    .visible     (mode.visible),
    .shape_under (mode.shape == cursor_pkg::SHAPE_UNDER),
    .blink_en    (mode.blink_en),
    .phase_on    (phase_on)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;

    localparam int HALF = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic       cmd_hide = 1'b0, cmd_block = 1'b0, cmd_under = 1'b0;
    logic       cmd_blink = 1'b0, cmd_steady = 1'b0;
    logic [2:0] pix_line = '0;
    logic [4:0] cell_row = '0, cur_row = 5'd3;
    logic [5:0] cell_col = '0, cur_col = 6'd10;
    logic       cursor_px;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = !clk;

    cursor_overlay dut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick),
        .cmd_hide(cmd_hide), .cmd_block(cmd_block), .cmd_under(cmd_under),
        .cmd_blink(cmd_blink), .cmd_steady(cmd_steady),
        .pix_line(pix_line), .cell_row(cell_row), .cell_col(cell_col),
        .cur_row(cur_row), .cur_col(cur_col), .cursor_px(cursor_px)
    );

    // {cmd[17:15], row[14:10], col[9:4], line[3:1], expected[0]}
    // cmd: 0 none, 1 hide, 2 block, 3 under, 4 blink, 5 steady
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {3'd0, 5'd3, 6'd10, 3'd0, 1'b1},
        {3'd0, 5'd3, 6'd10, 3'd7, 1'b1},
        {3'd0, 5'd3, 6'd11, 3'd4, 1'b0},
        {3'd0, 5'd4, 6'd10, 3'd4, 1'b0},
        {3'd3, 5'd3, 6'd10, 3'd7, 1'b1},
        {3'd0, 5'd3, 6'd10, 3'd6, 1'b0},
        {3'd0, 5'd3, 6'd10, 3'd0, 1'b0},
        {3'd1, 5'd3, 6'd10, 3'd7, 1'b0},
        {3'd0, 5'd3, 6'd10, 3'd0, 1'b0},
        {3'd2, 5'd3, 6'd10, 3'd2, 1'b1},
        {3'd5, 5'd3, 6'd10, 3'd5, 1'b1},
        {3'd3, 5'd3, 6'd10, 3'd7, 1'b1},
        {3'd0, 5'd2, 6'd10, 3'd7, 1'b0}
    };
    localparam string VREQ [NV] = '{"R1", "R3", "R3", "R3", "R4", "R4", "R4",
                                    "R2", "R2", "R5", "R7", "R5", "R4"};

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (cursor_px !== exp) begin
            n_fail++;
            $display("FAIL %s: cursor_px=%0b expected=%0b", req, cursor_px, exp);
        end
    endtask

    // mask bits: {steady, blink, under, block, hide}
    task automatic strobe(input logic [4:0] m);
        @(negedge clk);
        {cmd_steady, cmd_blink, cmd_under, cmd_block, cmd_hide} = m;
        @(negedge clk);
        {cmd_steady, cmd_blink, cmd_under, cmd_block, cmd_hide} = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_tick = 1'b1;
            @(negedge clk);
            frame_tick = 1'b0;
        end
    endtask

    task automatic look(input logic [4:0] r, input logic [5:0] c, input logic [2:0] l);
        cell_row = r;
        cell_col = c;
        pix_line = l;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: cycles=200000 expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        look(5'd3, 6'd10, 3'd3);
        check("R1 reset block lit", 1'b1);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][17:15] != 3'd0)
                strobe(5'(1 << (VEC[v][17:15] - 1)));
            look(VEC[v][14:10], VEC[v][9:4], VEC[v][3:1]);
            check(VREQ[v], VEC[v][0]);
        end

        // R10: output follows pixel inputs without a clock edge
        @(negedge clk);
        look(5'd3, 6'd10, 3'd7);
        check("R10 same-cycle lit", 1'b1);
        look(5'd3, 6'd9, 3'd7);
        check("R10 same-cycle dark", 1'b0);

        // R1: reset mid-run restores block, blinking, shown
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        look(5'd3, 6'd10, 3'd2);
        check("R1 reset block line2", 1'b1);
        look(5'd3, 6'd10, 3'd7);
        check("R1 reset block line7", 1'b1);

        // R6: blink window edges
        look(5'd3, 6'd10, 3'd0);
        ticks(HALF - 1);
        check("R6 shown before last tick", 1'b1);
        ticks(1);
        check("R6 dark after tick", 1'b0);
        ticks(HALF - 1);
        check("R6 still dark", 1'b0);
        ticks(1);
        check("R6 shown again", 1'b1);

        // R7: steady ignores ticks, even across a phase flip
        strobe(5'b10000);
        ticks(HALF);
        check("R7 steady lit", 1'b1);

        // R8: blink restarts in the shown half with a fresh count
        strobe(5'b01000);
        check("R8 shown after restart", 1'b1);
        ticks(HALF - 1);
        check("R8 count restarted", 1'b1);
        ticks(1);
        check("R8 dark after full count", 1'b0);

        // R5: underscore keeps blinking (phase is dark)
        strobe(5'b00100);
        look(5'd3, 6'd10, 3'd7);
        check("R5 blink kept", 1'b0);

        // R9: priorities
        strobe(5'b11000);
        check("R9 steady over blink", 1'b1);
        strobe(5'b00011);
        check("R9 hide over block", 1'b0);
        strobe(5'b00110);
        look(5'd3, 6'd10, 3'd3);
        check("R9 block over under", 1'b1);
        ticks(HALF);
        check("R9 R7 steady after ticks", 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule